// File: doc/BRIEF.md
# Chip-Select Burst Line Transfer Controller

This block is a bus master that moves one 16-byte, line-aligned block of data between an internal client and an external memory region. The client supplies the starting longword address, the direction, the write data for the whole line, and the settings of the target region. Those settings are a read-burst enable, a write-burst enable, the port width (32, 16 or 8 bits) and a count of programmed wait states. All of them are captured when the request is accepted.

When the enable for the requested direction is set, the line moves as one pipelined burst. Chip select and the direction strobe stay asserted across all beats. When that enable is clear, the line is split into back-to-back single bus cycles, and each of those cycles starts with an address clock in which all strobes are released. The longword order wraps inside the aligned line, starting from the requested longword. On narrow ports the sub-longword address counts upward inside each longword before the sequence moves to the next longword.

The request side is a valid/ready handshake. `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Read data leaves as one longword per `rd_valid` pulse. This output has no back-pressure, because the external bus cannot be held off, so the consumer must take every pulse. `done` pulses once per line.

Top module: `lbc_burst_ctrl`

## Requirements
- R1: `req_ready` is high only in idle. A request is taken only on an edge with `req_valid` and `req_ready` both high. Request and region inputs that change after acceptance have no effect on the transfer in progress.
- R2: After reset the controller is idle. `req_ready` is 1, `bus_cs_n`, `bus_oe_n` and `bus_we_n` are 1, and `done` and `rd_valid` are 0.
- R3: Bus addresses keep the line bits [AW-1:4] of the request. The longword index [3:2] runs start, start+1, start+2, start+3, modulo 4.
- R4: The `cfg_port_w` encoding is 0 = 32-bit (4 beats), 1 = 16-bit (8 beats), 2 = 8-bit (16 beats) and 3 = 32-bit. Inside each longword, bits [1:0] step upward by the port's byte count.
- R5: A read bursts when `cfg_burst_rd` is 1, and a write bursts when `cfg_burst_wr` is 1. The enable for the other direction has no effect. During a burst, `bus_cs_n` stays low from the first beat until the last beat is acknowledged.
- R6: Without a burst, every beat is its own bus cycle. Between cycles there is one address clock in which `bus_cs_n`, `bus_oe_n` and `bus_we_n` are all high.
- R7: With W programmed wait states, the first burst beat takes 3+W clocks and each later burst beat takes 2+W clocks. Each single cycle takes 3+W clocks. A high `bus_ta_n` in the data clock stretches the beat, and the address is held while it does.
- R8: For reads, `rd_valid` pulses for one clock once per longword, in wrap order. Bytes come from the low lanes of `bus_rdata`, and the lower byte address goes into the lower bits of `rd_data`.
- R9: For writes, the low port-width lanes of `bus_wdata` carry the line bytes at the current bus address, with byte k of `req_wdata` at bits [8k+7:8k]. While `bus_cs_n` is low, a read drives `bus_oe_n` low and `bus_we_n` high, and a write drives the reverse.
- R10: `done` is a one-clock pulse in the clock after the last beat is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_addr | input | AW-2 | Longword address of the first longword |
| req_wdata | input | 128 | Line write data, byte k at bits [8k+7:8k] |
| cfg_burst_rd | input | 1 | Region allows read bursts |
| cfg_burst_wr | input | 1 | Region allows write bursts |
| cfg_port_w | input | 2 | Region port width code |
| cfg_wait | input | WAIT_W | Programmed wait states per beat |
| rd_valid | output | 1 | One read longword presented |
| rd_data | output | 32 | Read longword |
| done | output | 1 | Line complete pulse |
| bus_addr | output | AW | External byte address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_wdata | output | 32 | Write data, low lanes used on narrow ports |
| bus_rdata | input | 32 | Read data, low lanes used on narrow ports |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |

## Verification
On every cycle, the assertions check four things. Chip select stays held between burst beats and drops between single cycles. The address stays frozen while acknowledge is withheld, and the line bits never change mid-transfer. The ready, done and read-valid pulse shapes also hold. Other properties are only visible to the bench's scenarios. These are the actual wrap order and sub-longword stepping for each port width, the exact clock counts of the 3-2-2-2 pattern with wait states and late acknowledge, and the byte placement of read and write data. The scenarios also show that an enable for the wrong direction, or inputs changed after acceptance, leave the transfer unchanged.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int LINE_BYTES = 16;
  localparam int LINE_BITS  = LINE_BYTES * 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_WAIT,
    ST_DATA,
    ST_NEXT
  } lbc_state_e;

  // log2 of beats per longword for a port width code
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lbc_addr_gen.sv
module lbc_addr_gen #(
  parameter int AW = 32
) (
  input  logic [AW-5:0] line_base,
  input  logic [1:0]    start_lw,
  input  logic [3:0]    beat,
  input  logic [1:0]    sh,
  output logic [AW-1:0] addr,
  output logic [1:0]    lw_pos,
  output logic [1:0]    sub,
  output logic          last_beat
);
  logic [1:0] step;
  logic [1:0] byte_off;
  logic [1:0] sub_max;

  always_comb begin
    case (sh)
      2'd1: begin
        step     = beat[2:1];
        sub      = {1'b0, beat[0]};
        byte_off = {beat[0], 1'b0};
        sub_max  = 2'd1;
      end
      2'd2: begin
        step     = beat[3:2];
        sub      = beat[1:0];
        byte_off = beat[1:0];
        sub_max  = 2'd3;
      end
      default: begin
        step     = beat[1:0];
        sub      = 2'd0;
        byte_off = 2'd0;
        sub_max  = 2'd0;
      end
    endcase
    lw_pos    = start_lw + step;
    addr      = {line_base, lw_pos, byte_off};
    last_beat = (step == 2'd3) && (sub == sub_max);
  end
endmodule

// File: rtl/lbc_rd_pack.sv
module lbc_rd_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic [1:0]  sh,
  input  logic [1:0]  sub,
  input  logic [31:0] lane_in,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  logic [31:0] acc_q;
  logic [31:0] merged;
  logic        word_end;

  always_comb begin
    merged = acc_q;
    case (sh)
      2'd1:    merged[{sub[0], 4'b0000} +: 16] = lane_in[15:0];
      2'd2:    merged[{sub, 3'b000} +: 8]      = lane_in[7:0];
      default: merged = lane_in;
    endcase
    case (sh)
      2'd1:    word_end = sub[0];
      2'd2:    word_end = (sub == 2'd3);
      default: word_end = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture && word_end;
      if (capture) acc_q <= merged;
      if (capture && word_end) rd_data <= merged;
    end
  end

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R8
endmodule

// File: rtl/lbc_wr_lane.sv
module lbc_wr_lane #(
  parameter int LB = 128
) (
  input  logic [LB-1:0] line,
  input  logic [1:0]    lw_pos,
  input  logic [1:0]    sub,
  input  logic [1:0]    sh,
  output logic [31:0]   wdata
);
  logic [31:0] word;

  always_comb begin
    word = line[{lw_pos, 5'b00000} +: 32];
    case (sh)
      2'd1:    wdata = {16'h0000, word[{sub[0], 4'b0000} +: 16]};
      2'd2:    wdata = {24'h000000, word[{sub, 3'b000} +: 8]};
      default: wdata = word;
    endcase
  end
endmodule

// File: rtl/lbc_burst_ctrl.sv
module lbc_burst_ctrl
  import lbc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int WAIT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:2]        req_addr,
  input  logic [LINE_BITS-1:0] req_wdata,
  input  logic                 cfg_burst_rd,
  input  logic                 cfg_burst_wr,
  input  logic [1:0]           cfg_port_w,
  input  logic [WAIT_W-1:0]    cfg_wait,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic                 done,
  output logic [AW-1:0]        bus_addr,
  output logic                 bus_cs_n,
  output logic                 bus_oe_n,
  output logic                 bus_we_n,
  output logic [31:0]          bus_wdata,
  input  logic [31:0]          bus_rdata,
  input  logic                 bus_ta_n
);
  lbc_state_e           st_q;
  logic                 wr_q;
  logic                 burst_q;
  logic [1:0]           sh_q;
  logic [WAIT_W-1:0]    wait_q;
  logic [WAIT_W-1:0]    wcnt_q;
  logic [AW-5:0]        base_q;
  logic [1:0]           start_q;
  logic [3:0]           beat_q;
  logic [LINE_BITS-1:0] line_q;
  logic                 done_q;

  logic [1:0] lw_pos;
  logic [1:0] sub;
  logic       last_beat;
  logic       ack;

  assign ack = (st_q == ST_DATA) && !bus_ta_n;

  lbc_addr_gen #(.AW(AW)) u_addr (
    .line_base (base_q),
    .start_lw  (start_q),
    .beat      (beat_q),
    .sh        (sh_q),
    .addr      (bus_addr),
    .lw_pos    (lw_pos),
    .sub       (sub),
    .last_beat (last_beat)
  );

  lbc_wr_lane #(.LB(LINE_BITS)) u_wr (
    .line   (line_q),
    .lw_pos (lw_pos),
    .sub    (sub),
    .sh     (sh_q),
    .wdata  (bus_wdata)
  );

  lbc_rd_pack u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (ack && !wr_q),
    .sh       (sh_q),
    .sub      (sub),
    .lane_in  (bus_rdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      sh_q    <= 2'd0;
      wait_q  <= '0;
      wcnt_q  <= '0;
      base_q  <= '0;
      start_q <= 2'd0;
      beat_q  <= 4'd0;
      line_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          burst_q <= req_write ? cfg_burst_wr : cfg_burst_rd;
          sh_q    <= width_shift(cfg_port_w);
          wait_q  <= cfg_wait;
          base_q  <= req_addr[AW-1:4];
          start_q <= req_addr[3:2];
          line_q  <= req_wdata;
          beat_q  <= 4'd0;
          st_q    <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_SETUP;
        ST_SETUP, ST_NEXT: begin
          wcnt_q <= wait_q;
          st_q   <= (wait_q == '0) ? ST_DATA : ST_WAIT;
        end
        ST_WAIT: begin
          wcnt_q <= wcnt_q - 1'b1;
          if (wcnt_q <= 1) st_q <= ST_DATA;
        end
        ST_DATA: if (!bus_ta_n) begin
          if (last_beat) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + 4'd1;
            st_q   <= burst_q ? ST_NEXT : ST_ADDR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign bus_cs_n  = (st_q == ST_IDLE) || (st_q == ST_ADDR);
  assign bus_oe_n  = bus_cs_n || wr_q;
  assign bus_we_n  = bus_cs_n || !wr_q;

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_LINE_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !done) |=> (bus_addr[AW-1:4] == $past(bus_addr[AW-1:4]))); // R3
  AST_BURST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_q && ack && !last_beat) |=> !bus_cs_n); // R5
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_q && ack && !last_beat) |=> (bus_cs_n && bus_oe_n && bus_we_n)); // R6
  AST_ADDR_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DATA) && bus_ta_n) |=> ($stable(bus_addr) && !bus_cs_n)); // R7
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && last_beat) |=> (done && req_ready)); // R10
endmodule

// File: tb/lbc_burst_ctrl_tb.sv
module lbc_burst_ctrl_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:2] req_addr;
  logic [127:0]  req_wdata;
  logic          cfg_burst_rd, cfg_burst_wr;
  logic [1:0]    cfg_port_w;
  logic [3:0]    cfg_wait;
  logic          rd_valid, done;
  logic [31:0]   rd_data;
  logic [AW-1:0] bus_addr;
  logic          bus_cs_n, bus_oe_n, bus_we_n, bus_ta_n;
  logic [31:0]   bus_wdata, bus_rdata;

  int errors = 0;
  int checks = 0;

  lbc_burst_ctrl #(.AW(AW), .WAIT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_burst_rd(cfg_burst_rd), .cfg_burst_wr(cfg_burst_wr),
    .cfg_port_w(cfg_port_w), .cfg_wait(cfg_wait), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ta_n(bus_ta_n)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[11:8], a[15:12]};
  endfunction

  always_comb bus_rdata = {mb(bus_addr + 3), mb(bus_addr + 2), mb(bus_addr + 1), mb(bus_addr)};

  logic [31:0] g_addr [32];
  logic [31:0] g_wd   [32];
  logic [31:0] g_rd   [8];
  int g_na, g_nrd, g_cyc, g_rel, g_viol;
  bit g_busy_ready;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_xfer(input bit wr, input logic [31:0] a, input logic [127:0] wl,
                         input bit brd, input bit bwr, input logic [1:0] pw,
                         input logic [3:0] w, input int ta_rel, input bit scramble);
    bit was_low;
    logic [31:0] last;
    int n;
    @(negedge clk);
    req_write = wr; req_addr = a[31:2]; req_wdata = wl;
    cfg_burst_rd = brd; cfg_burst_wr = bwr; cfg_port_w = pw; cfg_wait = w;
    req_valid = 1'b1;
    bus_ta_n = (ta_rel > 0);
    g_na = 0; g_nrd = 0; g_rel = 0; g_viol = 0; g_busy_ready = 1'b0;
    was_low = 1'b0; last = '0;
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_wait = 4'hF; cfg_port_w = 2'd2; cfg_burst_rd = ~brd; cfg_burst_wr = ~bwr;
      req_addr = '0; req_write = ~wr; req_wdata = ~wl;
    end
    n = 1;
    while (1) begin
      bus_ta_n = (n < ta_rel);
      if (n == 4) g_busy_ready = req_ready;
      if (scramble && n == 4) req_valid = 1'b1;
      if (scramble && n == 6) req_valid = 1'b0;
      if (rd_valid && g_nrd < 8) begin g_rd[g_nrd] = rd_data; g_nrd++; end
      if (!bus_cs_n) begin
        if (!was_low || bus_addr != last) begin
          if (g_na < 32) begin g_addr[g_na] = bus_addr; g_na++; end
          last = bus_addr;
        end
        if (g_na > 0) g_wd[g_na-1] = bus_wdata;
        if (wr ? (bus_we_n || !bus_oe_n) : (bus_oe_n || !bus_we_n)) g_viol++;
        was_low = 1'b1;
      end else begin
        if (was_low && !done) g_rel++;
        was_low = 1'b0;
      end
      if (done || n >= 600) break;
      @(negedge clk);
      n++;
    end
    g_cyc = n;
    bus_ta_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done pulse width", done, 0);
  endtask

  task automatic verify(input bit wr, input logic [31:0] a, input logic [127:0] wl,
                        input logic [1:0] pw, input int w, input bit burst, input int extra);
    int sh, nb, pb, exp_cyc;
    logic [31:0] msk;
    sh = (pw == 2'd1) ? 1 : (pw == 2'd2) ? 2 : 0;
    nb = 4 << sh;
    pb = 4 >> sh;
    msk = (pb == 4) ? 32'hFFFF_FFFF : (pb == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
    exp_cyc = burst ? (3 + w) + (nb - 1) * (2 + w) + 1 + extra : nb * (3 + w) + 1 + extra;
    chk(g_cyc == exp_cyc, "R7", "clocks to done", g_cyc, exp_cyc);
    chk(g_na == nb, "R4", "beat count", g_na, nb);
    for (int i = 0; i < nb && i < g_na; i++) begin
      int lw, sb, off;
      logic [31:0] ea, ed;
      lw = (a[3:2] + (i >> sh)) & 3;
      sb = i & ((1 << sh) - 1);
      off = lw * 4 + sb * pb;
      ea = {a[31:4], 4'b0000} + off;
      chk(g_addr[i] == ea, "R3", "beat address", g_addr[i], ea);
      if (wr) begin
        ed = 32'(wl >> (off * 8)) & msk;
        chk((g_wd[i] & msk) == ed, "R9", "write lanes", g_wd[i] & msk, ed);
      end
    end
    if (burst) chk(g_rel == 0, "R5", "cs releases in burst", g_rel, 0);
    else       chk(g_rel == nb - 1, "R6", "cs releases in singles", g_rel, nb - 1);
    chk(g_viol == 0, "R9", "strobe direction errors", g_viol, 0);
    if (wr) chk(g_nrd == 0, "R8", "rd_valid on write", g_nrd, 0);
    else begin
      chk(g_nrd == 4, "R8", "read longwords", g_nrd, 4);
      for (int k = 0; k < 4 && k < g_nrd; k++) begin
        logic [31:0] b, e;
        b = {a[31:4], 4'b0000} + (((a[3:2] + k) & 3) * 4);
        e = {mb(b + 3), mb(b + 2), mb(b + 1), mb(b)};
        chk(g_rd[k] == e, "R8", "read longword", g_rd[k], e);
      end
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
    chk(bus_cs_n && bus_oe_n && bus_we_n, "R2", "strobes after reset",
        {bus_cs_n, bus_oe_n, bus_we_n}, 3'b111);
    chk(!done && !rd_valid, "R2", "pulses after reset", {done, rd_valid}, 0);
  endtask

  task automatic t_burst_rd32;
    do_xfer(1'b0, 32'h0001_2344, '0, 1'b1, 1'b0, 2'd0, 4'd0, 0, 1'b0);
    verify(1'b0, 32'h0001_2344, '0, 2'd0, 0, 1'b1, 0);
  endtask

  task automatic t_burst_rd16_wait;
    do_xfer(1'b0, 32'h00A0_0B38, '0, 1'b1, 1'b1, 2'd1, 4'd1, 0, 1'b0);
    verify(1'b0, 32'h00A0_0B38, '0, 2'd1, 1, 1'b1, 0);
  endtask

  task automatic t_single_rd8;
    // R5: write enable alone must not make a read burst
    do_xfer(1'b0, 32'h0000_5C7C, '0, 1'b0, 1'b1, 2'd2, 4'd0, 0, 1'b0);
    verify(1'b0, 32'h0000_5C7C, '0, 2'd2, 0, 1'b0, 0);
  endtask

  task automatic t_burst_wr16;
    logic [127:0] wl = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    do_xfer(1'b1, 32'h0300_004C, wl, 1'b0, 1'b1, 2'd1, 4'd0, 0, 1'b0);
    verify(1'b1, 32'h0300_004C, wl, 2'd1, 0, 1'b1, 0);
  endtask

  task automatic t_single_wr32_wait;
    logic [127:0] wl = 128'h11223344_55667788_99AABBCC_DDEEFF00;
    do_xfer(1'b1, 32'h0000_0F08, wl, 1'b1, 1'b0, 2'd0, 4'd2, 0, 1'b0);
    verify(1'b1, 32'h0000_0F08, wl, 2'd0, 2, 1'b0, 0);
  endtask

  task automatic t_late_ack;
    // R7: acknowledge withheld until clock 5 adds two clocks to the first beat
    do_xfer(1'b0, 32'h0000_1230, '0, 1'b1, 1'b0, 2'd0, 4'd0, 5, 1'b0);
    verify(1'b0, 32'h0000_1230, '0, 2'd0, 0, 1'b1, 2);
  endtask

  task automatic t_capture_busy;
    // R1: inputs scrambled after acceptance, second request offered while busy
    do_xfer(1'b0, 32'h0777_7778, '0, 1'b1, 1'b0, 2'd3, 4'd0, 0, 1'b1);
    chk(g_busy_ready == 1'b0, "R1", "ready while busy", g_busy_ready, 0);
    verify(1'b0, 32'h0777_7778, '0, 2'd3, 0, 1'b1, 0);
    chk(req_ready == 1'b1, "R1", "idle after busy offer dropped", req_ready, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_burst_rd = 1'b0; cfg_burst_wr = 1'b0; cfg_port_w = 2'd0; cfg_wait = 4'd0;
    bus_ta_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_rd32();
    t_burst_rd16_wait();
    t_single_rd8();
    t_burst_wr16();
    t_single_wr32_wait();
    t_late_ack();
    t_capture_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule